// File: doc/BRIEF.md
# Three-Counter Latch and Readback Unit

This unit is the read side of a three-channel, 16-bit down-counter timer. The counters themselves, with their counting modes, gate and output logic, sit elsewhere. They feed this unit with a live count, a live status byte and a one-byte or two-byte access format for each channel.

Byte writes to the control port are decoded into one of three kinds of command:

- a latch command for a single counter;
- a read-back command that can freeze the count and/or status of several counters at once;
- a mode write, which discards any pending snapshot for its counter.

Each counter has its own data read port. A read returns bytes in a fixed order:

1. a held status byte, if one is pending;
2. then the held count bytes;
3. after that, the live count.

The read data is combinational from the current state. All state changes happen on the clock edge that ends the access.

Top module: `tmr_latch_readback`

## Requirements
- R1: After reset, no count or status is held and every byte pointer is at the low byte. A read of a two-byte counter returns the live low byte, and the next read returns the live high byte.
- R2: A control write whose bits 7:6 are 00, 01 or 10 (counter 0, 1 or 2) and whose bits 5:4 are 00 captures that counter's live count. Later reads return the captured low byte, then the captured high byte, whatever the live count does meanwhile. Bits 3:0 of such a write are ignored.
- R3: A count capture request for a counter whose captured count is still unread is ignored. The first captured value is kept.
- R4: A control write with bits 7:6 = 11 is a read-back command. Bit 5 = 0 captures the count and bit 4 = 0 captures the status of every counter selected by bit 1 (counter 0), bit 2 (counter 1) and bit 3 (counter 2). Counters that are not selected are untouched.
- R5: When both status and count are held, the first read returns the status byte. The next one or two reads return the held count. Reads after that return the live count.
- R6: A status capture request while a status byte is held and unread is ignored. Reading the status byte releases it, so a later request captures again.
- R7: A partly read two-byte held count survives reads, commands and mode writes aimed at other counters. Its next read still returns the held high byte.
- R8: In one-byte format only the low byte is returned. One read releases a held count, and the byte pointer does not advance.
- R9: With no count held, successive reads of a two-byte counter alternate between the live low and high bytes.
- R10: A control write with bits 7:6 below 11 and bits 5:4 not 00 is a mode write. It drops any held count and status of that counter and returns its byte pointer to the low byte.
- R11: A read in the same cycle as a capture command returns the value from before the command. The capture is in effect from the next cycle.
- R12: A read with port select 3 returns 8'hFF and changes no counter's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWr | input | 1 | Control port write strobe |
| ctlData | input | 8 | Control port write byte |
| rdEn | input | 1 | Data port read strobe |
| rdSel | input | 2 | Data port select, 0 to 2 for the counters |
| rdData | output | 8 | Read byte, valid in the cycle of rdEn |
| liveCount | input | 48 | Live counts, counter i at bits 16i+15:16i |
| liveStatus | input | 24 | Live status bytes, counter i at bits 8i+7:8i |
| twoByte | input | 3 | Per counter: 1 = low/high byte pair, 0 = low byte only |

## Verification
A read byte is due in the very cycle its rdEn is high, because rdData is a multiplexer over the current held and pointer state. The bench raises its strobes two time units after a rising edge and samples rdData on the following falling edge. A capture or pointer step is visible to the first read issued after the edge that ends the command's cycle. The scoreboard therefore holds one expected byte per read, in issue order, and checks the same-cycle cases (R11) against the value from before the command.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
  localparam int NUM_CTR = 3;
  localparam int CNT_W   = 16;
  localparam int STS_W   = 8;
  localparam int SEL_W   = $clog2(NUM_CTR + 1);

  typedef enum logic [2:0] {
    SRC_STS     = 3'd0,
    SRC_LAT_LO  = 3'd1,
    SRC_LAT_HI  = 3'd2,
    SRC_LIVE_LO = 3'd3,
    SRC_LIVE_HI = 3'd4,
    SRC_NONE    = 3'd5
  } rdSrc_e;

  typedef struct packed {
    logic [NUM_CTR-1:0] capCnt;
    logic [NUM_CTR-1:0] capSts;
    rdSrc_e             rdSrc;
  } tlrStrobe_t;
endpackage

// File: rtl/tlr_chan_ctl.sv
module tlr_chan_ctl
  import tlr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   latchCntReq,
  input  logic   latchStsReq,
  input  logic   modeWr,
  input  logic   rdHit,
  input  logic   twoByte,
  output logic   capCnt,
  output logic   capSts,
  output rdSrc_e src
);
  logic cntPend, stsPend, ptrHi;
  logic lastByte;

  always_comb begin
    capCnt   = latchCntReq && !cntPend && !modeWr;
    capSts   = latchStsReq && !stsPend && !modeWr;
    lastByte = !twoByte || ptrHi;
    if (stsPend)                src = SRC_STS;
    else if (twoByte && ptrHi)  src = cntPend ? SRC_LAT_HI : SRC_LIVE_HI;
    else                        src = cntPend ? SRC_LAT_LO : SRC_LIVE_LO;
  end

  always_ff @(posedge clk) begin
    if (!rstN || modeWr) begin
      cntPend <= 1'b0;
      stsPend <= 1'b0;
      ptrHi   <= 1'b0;
    end else begin
      if (rdHit) begin
        if (stsPend) begin
          stsPend <= 1'b0;
        end else begin
          if (lastByte) cntPend <= 1'b0;
          ptrHi <= twoByte ? !ptrHi : 1'b0;
        end
      end
      if (capCnt) cntPend <= 1'b1;
      if (capSts) stsPend <= 1'b1;
    end
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntPend && !modeWr && !rdHit |=> cntPend);
  // R5
  sts_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    stsPend && rdHit && !modeWr && !capCnt |=> !stsPend && (cntPend == $past(cntPend)));
  // R10
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> !cntPend && !stsPend && !ptrHi);
  // R8
  one_byte_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !twoByte && rdHit && !stsPend && !modeWr && !latchCntReq |=> !cntPend && !ptrHi);
endmodule

// File: rtl/tlr_ctrl.sv
module tlr_ctrl
  import tlr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWr,
  input  logic [7:0]         ctlData,
  input  logic               rdEn,
  input  logic [SEL_W-1:0]   rdSel,
  input  logic [NUM_CTR-1:0] twoByte,
  output tlrStrobe_t         strobe
);
  localparam logic [1:0] RB_CODE = 2'b11;

  logic               isReadBack;
  logic [NUM_CTR-1:0] latchCntReq, latchStsReq, modeWr, rdHit, capCnt, capSts;
  rdSrc_e             srcArr [NUM_CTR];

  assign isReadBack = ctlWr && (ctlData[7:6] == RB_CODE);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chan
    logic hitCtr;
    assign hitCtr = ctlWr && (ctlData[7:6] == 2'(i));
    assign latchCntReq[i] = (hitCtr && ctlData[5:4] == 2'b00)
                         || (isReadBack && !ctlData[5] && ctlData[i+1]);
    assign latchStsReq[i] = isReadBack && !ctlData[4] && ctlData[i+1];
    assign modeWr[i]      = hitCtr && (ctlData[5:4] != 2'b00);
    assign rdHit[i]       = rdEn && (rdSel == SEL_W'(i));

    tlr_chan_ctl u_chan (
      .clk         (clk),
      .rstN        (rstN),
      .latchCntReq (latchCntReq[i]),
      .latchStsReq (latchStsReq[i]),
      .modeWr      (modeWr[i]),
      .rdHit       (rdHit[i]),
      .twoByte     (twoByte[i]),
      .capCnt      (capCnt[i]),
      .capSts      (capSts[i]),
      .src         (srcArr[i])
    );
  end

  always_comb begin
    strobe.capCnt = capCnt;
    strobe.capSts = capSts;
    strobe.rdSrc  = SRC_NONE;
    for (int k = 0; k < NUM_CTR; k++)
      if (rdSel == SEL_W'(k)) strobe.rdSrc = srcArr[k];
  end

  // R12
  no_ctr_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && (rdSel >= SEL_W'(NUM_CTR)) |-> (rdHit == '0));
  // R4
  rb_no_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    isReadBack |-> (modeWr == '0));
endmodule

// File: rtl/tlr_datapath.sv
module tlr_datapath
  import tlr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  tlrStrobe_t               strobe,
  input  logic [SEL_W-1:0]         rdSel,
  input  logic [NUM_CTR*CNT_W-1:0] liveCount,
  input  logic [NUM_CTR*STS_W-1:0] liveStatus,
  output logic [7:0]               rdData
);
  logic [CNT_W-1:0] cntHold [NUM_CTR];
  logic [STS_W-1:0] stsHold [NUM_CTR];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntHold[i] <= '0;
        stsHold[i] <= '0;
      end else begin
        if (strobe.capCnt[i]) cntHold[i] <= liveCount[i*CNT_W +: CNT_W];
        if (strobe.capSts[i]) stsHold[i] <= liveStatus[i*STS_W +: STS_W];
      end
    end

    // R2
    cap_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capCnt[i] |=> cntHold[i] == $past(liveCount[i*CNT_W +: CNT_W]));
    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.capCnt[i] |=> $stable(cntHold[i]));
  end

  always_comb begin
    logic [CNT_W-1:0] heldC, liveC;
    logic [STS_W-1:0] heldS;
    heldC = '0;
    liveC = '0;
    heldS = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (rdSel == SEL_W'(k)) begin
        heldC = cntHold[k];
        heldS = stsHold[k];
        liveC = liveCount[k*CNT_W +: CNT_W];
      end
    end
    unique case (strobe.rdSrc)
      SRC_STS:     rdData = heldS;
      SRC_LAT_LO:  rdData = heldC[7:0];
      SRC_LAT_HI:  rdData = heldC[15:8];
      SRC_LIVE_LO: rdData = liveC[7:0];
      SRC_LIVE_HI: rdData = liveC[15:8];
      default:     rdData = 8'hFF;
    endcase
  end
endmodule

// File: rtl/tmr_latch_readback.sv
module tmr_latch_readback
  import tlr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWr,
  input  logic [7:0]  ctlData,
  input  logic        rdEn,
  input  logic [1:0]  rdSel,
  output logic [7:0]  rdData,
  input  logic [47:0] liveCount,
  input  logic [23:0] liveStatus,
  input  logic [2:0]  twoByte
);
  tlrStrobe_t strobe;

  tlr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctlWr   (ctlWr),
    .ctlData (ctlData),
    .rdEn    (rdEn),
    .rdSel   (rdSel),
    .twoByte (twoByte),
    .strobe  (strobe)
  );

  tlr_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdSel      (rdSel),
    .liveCount  (liveCount),
    .liveStatus (liveStatus),
    .rdData     (rdData)
  );
endmodule

// File: tb/tmr_latch_readback_test.sv
module tmr_latch_readback_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWr = 1'b0;
  logic [7:0]  ctlData = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdSel = '0;
  logic [7:0]  rdData;
  logic [47:0] liveCount = '0;
  logic [23:0] liveStatus = '0;
  logic [2:0]  twoByte = 3'b111;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;
  logic [15:0] expQ [$];

  tmr_latch_readback uut (.*);

  always #5 clk = ~clk;

  // scoreboard monitor: one expected byte per read, checked mid-cycle
  always @(negedge clk) begin
    if (rdEn) begin
      logic [15:0] e;
      e = expQ.pop_front();
      compared++;
      if (rdData !== e[7:0]) begin
        mismatched++;
        $display("FAIL R%0d: read port %0d got %h expected %h", e[15:8], rdSel, rdData, e[7:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      mismatched++;
      compared++;
      $display("FAIL R0: watchdog expired, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic endCycle();
    @(posedge clk);
    #2;
    ctlWr = 1'b0;
    rdEn  = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);
    ctlWr = 1'b1;
    ctlData = d;
    endCycle();
  endtask

  task automatic rd(input int sel, input logic [7:0] exp, input int req);
    expQ.push_back({8'(req), exp});
    rdEn = 1'b1;
    rdSel = 2'(sel);
    endCycle();
  endtask

  task automatic rdCmd(input int sel, input logic [7:0] d, input logic [7:0] exp, input int req);
    expQ.push_back({8'(req), exp});
    rdEn = 1'b1;
    rdSel = 2'(sel);
    ctlWr = 1'b1;
    ctlData = d;
    endCycle();
  endtask

  task automatic setCnt(input int c, input logic [15:0] v);
    liveCount[c*16 +: 16] = v;
  endtask

  task automatic setSts(input int c, input logic [7:0] v);
    liveStatus[c*8 +: 8] = v;
  endtask

  initial begin
    setCnt(0, 16'h1234); setCnt(1, 16'hABCD); setCnt(2, 16'h5A0F);
    setSts(0, 8'h31);    setSts(1, 8'h72);    setSts(2, 8'hC4);
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    endCycle();

    // R1: reset state, live low then high
    rd(0, 8'h34, 1); rd(0, 8'h12, 1);

    // R2: single latch command (low nibble ignored), live moves on
    cmd(8'h0F);
    setCnt(0, 16'h9988);
    rd(0, 8'h34, 2); rd(0, 8'h12, 2);
    // R9: live alternation after release
    rd(0, 8'h88, 9); rd(0, 8'h99, 9);

    // R3: second latch while pending ignored
    cmd(8'h40);
    setCnt(1, 16'h1111);
    cmd(8'h40);
    rd(1, 8'hCD, 3); rd(1, 8'hAB, 3);

    // R4 / R5: read-back count+status of counters 2 and 0
    cmd(8'hCA);
    setCnt(2, 16'h7777); setSts(2, 8'h00);
    setCnt(0, 16'h2222); setSts(0, 8'h00);
    setCnt(1, 16'h3344);
    rd(1, 8'h44, 4); rd(1, 8'h33, 4);   // R4: counter 1 not selected
    rd(2, 8'hC4, 5); rd(2, 8'h0F, 5); rd(2, 8'h5A, 5);
    rd(2, 8'h77, 5); rd(2, 8'h77, 5);
    rd(0, 8'h31, 5); rd(0, 8'h88, 5); rd(0, 8'h99, 5); rd(0, 8'h22, 5); rd(0, 8'h22, 5);

    // R6: status-only read-back, repeat ignored, release then recapture
    cmd(8'hE4);
    setSts(1, 8'h05);
    cmd(8'hE4);
    rd(1, 8'h72, 6); rd(1, 8'h44, 6); rd(1, 8'h33, 6);
    cmd(8'hE4);
    rd(1, 8'h05, 6); rd(1, 8'h44, 6); rd(1, 8'h33, 6);

    // R7: interleaved two-byte read
    setCnt(2, 16'h6655);
    cmd(8'h80);
    setCnt(2, 16'h0000);
    rd(2, 8'h55, 7);
    setCnt(0, 16'h2A1B);
    cmd(8'h00);
    rd(0, 8'h1B, 7); rd(0, 8'h2A, 7);
    cmd(8'h74);
    rd(1, 8'h44, 7); rd(1, 8'h33, 7);
    rd(2, 8'h66, 7); rd(2, 8'h00, 7);
    rd(2, 8'h00, 7);

    // R8: one-byte format
    twoByte[1] = 1'b0;
    cmd(8'h40);
    setCnt(1, 16'h0102);
    rd(1, 8'h44, 8); rd(1, 8'h02, 8); rd(1, 8'h02, 8);
    twoByte[1] = 1'b1;

    // R10: mode write drops held count/status
    setCnt(0, 16'h4321);
    cmd(8'hC2);
    setCnt(0, 16'h0F0E);
    cmd(8'h34);
    rd(0, 8'h0E, 10); rd(0, 8'h0F, 10);
    setCnt(2, 16'h2211);
    rd(2, 8'h11, 10);
    cmd(8'hB6);
    rd(2, 8'h11, 10); rd(2, 8'h22, 10);

    // R11: same-cycle read returns pre-command value
    rdCmd(1, 8'hE4, 8'h02, 11);
    rd(1, 8'h05, 11); rd(1, 8'h01, 11);
    setCnt(0, 16'h5566);
    rdCmd(0, 8'h00, 8'h66, 11);
    setCnt(0, 16'h0000);
    rd(0, 8'h55, 11); rd(0, 8'h00, 11);

    // R12: unused port select
    rd(3, 8'hFF, 12);
    rd(2, 8'h11, 12); rd(2, 8'h22, 12);

    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule